// File: doc/BRIEF.md
# Descriptor-Chained Channel Sequencer

This block sits in front of a shared processing engine and feeds it work from several independent channels. Each channel owns a live descriptor-pointer register and a pending-work counter, and both are written over a small register bus. Software builds a linked list of descriptors in memory, loads the address of the first one into the pointer register, and then adds a count to the channel's counter. A channel with a non-zero count and no latched error asks for the engine.

A round-robin arbiter picks one requesting channel. The block then reads that channel's four-word descriptor through a valid/ready memory read port and hands the two parameter words to the engine with a one-cycle start strobe. The channel keeps the engine until the engine reports completion. At that point the block takes one off the count, moves the next-pointer word into the pointer register if the descriptor asks for chaining, and may raise a sticky per-channel interrupt flag. If a memory read fails, the channel stops: its count is zeroed and an error flag is latched. The channel does not run again until software clears that flag.

Register address = {channel, select}. The select values are 0 for the pointer, 1 for the counter and 2 for status.

Top module: `desc_chain_seq`

## Requirements
- R1: Synchronous active-high reset clears every pointer, counter, interrupt flag and error flag to zero, and leaves the memory port and the engine start strobe idle.
- R2: The pointer register (select 0) takes the whole 32-bit write data, and software can read it back at any time.
- R3: A write to the counter (select 1) adds the written value to the current count rather than replacing it. The sum saturates at 2^SW-1 (255 by default).
- R4: A channel whose count is non-zero and whose error flag is clear requests the engine. Once granted, the block reads four words at pointer+0, +4, +8 and +12, in that order and one at a time. The address is held steady while a request is not accepted.
- R5: After the fourth word arrives, eng_start pulses for exactly one cycle. The pulse carries the channel index and, as eng_param0 and eng_param1, descriptor words 2 and 3.
- R6: On eng_done the owning channel's count drops by one. If bit 2 (chain) of descriptor word 1 is set, word 0 is copied into the pointer register. If that bit is clear, the pointer is left unchanged.
- R7: Arbitration is round-robin, starting after the most recently granted channel. The grant is held until completion, and no other descriptor is fetched while the engine runs.
- R8: If bit 0 (interrupt request) of descriptor word 1 is set, the channel's interrupt flag (status bit 0, irq_o) is set on completion. The flag stays set until software writes 1 to status bit 0.
- R9: A memory response with mem_rsp_err set latches the channel's error flag (status bit 1, err_o), zeroes its count and starts no engine operation. The channel does not fetch again until 1 is written to status bit 1.
- R10: eng_done is ignored outside the execution phase. It changes no count and no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CH_W+2 | {channel, select} register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DW | Read response word |
| mem_rsp_err | input | 1 | Read response carries an error |
| eng_start | output | 1 | One-cycle engine start strobe |
| eng_chan | output | CH_W | Channel that owns the engine |
| eng_param0 | output | DW | Descriptor word 2 |
| eng_param1 | output | DW | Descriptor word 3 |
| eng_done | input | 1 | Engine completion pulse |
| irq_o | output | NCH | Sticky per-channel interrupt flags |
| err_o | output | NCH | Per-channel error flags |

## Verification
The sequencing function is run on three kinds of descriptor list. A lone descriptor with chaining off separates a pointer that holds from one that reloads. A two-entry chain whose first entry links to a second that carries an interrupt request separates a reload from the wrong word and an interrupt raised one descriptor too early. Self-linked descriptors queued on three channels behind a stalled engine expose fixed-priority grants and grants that hop before completion. Two further patterns hold the memory port stalled: a completion pulse sent in the middle of a fetch, and an out-of-range descriptor address that returns a memory error. These check that stray completions and failed reads leave the count and pointer exactly as the requirements say.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [2:0] {
        FS_IDLE   = 3'd0,
        FS_REQ    = 3'd1,
        FS_WAIT   = 3'd2,
        FS_LAUNCH = 3'd3,
        FS_EXEC   = 3'd4
    } fetch_st_e;

    localparam int DESC_WORDS     = 4;
    localparam int WI_W           = 2;
    localparam int CTRL_IRQ_BIT   = 0;
    localparam int CTRL_CHAIN_BIT = 2;

    localparam logic [1:0] SEL_PTR  = 2'd0;
    localparam logic [1:0] SEL_SEMA = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

endpackage

// File: rtl/dcs_rr_arb.sv
module dcs_rr_arb #(
    parameter int NCH = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  req,
    input  logic            take,
    output logic            any,
    output logic [CH_W-1:0] gnt_idx
);

    logic [CH_W-1:0] last_d, last_q;

    always_comb begin
        any     = 1'b0;
        gnt_idx = last_q;
        for (int off = 1; off <= NCH; off++) begin
            int idx;
            idx = (int'(last_q) + off) % NCH;
            if (!any && req[idx]) begin
                any     = 1'b1;
                gnt_idx = CH_W'(idx);
            end
        end
        last_d = take ? gnt_idx : last_q;
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= CH_W'(NCH - 1);
        else     last_q <= last_d;
    end

    assert_gnt_in_req_R7: assert property (@(posedge clk) disable iff (rst)
        any |-> req[gnt_idx]);

    assert_work_conserving_R7: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> any);

endmodule

// File: rtl/dcs_fetch.sv
module dcs_fetch import dcs_pkg::*; #(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gnt_any,
    input  logic [CH_W-1:0] gnt_idx,
    input  logic [AW-1:0]   gnt_ptr,
    output logic            take,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [AW-1:0]   mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [DW-1:0]   mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            eng_start,
    output logic [CH_W-1:0] eng_chan,
    output logic [DW-1:0]   eng_param0,
    output logic [DW-1:0]   eng_param1,
    input  logic            eng_done,
    output logic            cpl_valid,
    output logic [CH_W-1:0] cpl_chan,
    output logic [AW-1:0]   cpl_next,
    output logic            cpl_chain,
    output logic            cpl_irq,
    output logic            err_valid,
    output logic [CH_W-1:0] err_chan
);

    typedef struct packed {
        fetch_st_e       st;
        logic [CH_W-1:0] chan;
        logic [AW-1:0]   base;
        logic [WI_W-1:0] widx;
        logic [DW-1:0]   nxt;
        logic            chain;
        logic            irq;
        logic [DW-1:0]   p0;
        logic [DW-1:0]   p1;
    } fstate_t;

    fstate_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        take          = 1'b0;
        mem_req_valid = 1'b0;
        eng_start     = 1'b0;
        cpl_valid     = 1'b0;
        err_valid     = 1'b0;
        mem_req_addr  = s_q.base + {{(AW-WI_W-2){1'b0}}, s_q.widx, 2'b00};
        case (s_q.st)
            FS_IDLE: begin
                if (gnt_any) begin
                    take     = 1'b1;
                    s_d.chan = gnt_idx;
                    s_d.base = gnt_ptr;
                    s_d.widx = '0;
                    s_d.st   = FS_REQ;
                end
            end
            FS_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) s_d.st = FS_WAIT;
            end
            FS_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        err_valid = 1'b1;
                        s_d.st    = FS_IDLE;
                    end else begin
                        case (s_q.widx)
                            2'd0: s_d.nxt = mem_rsp_data;
                            2'd1: begin
                                s_d.chain = mem_rsp_data[CTRL_CHAIN_BIT];
                                s_d.irq   = mem_rsp_data[CTRL_IRQ_BIT];
                            end
                            2'd2: s_d.p0 = mem_rsp_data;
                            default: s_d.p1 = mem_rsp_data;
                        endcase
                        if (s_q.widx == WI_W'(DESC_WORDS - 1)) begin
                            s_d.st = FS_LAUNCH;
                        end else begin
                            s_d.widx = s_q.widx + 1'b1;
                            s_d.st   = FS_REQ;
                        end
                    end
                end
            end
            FS_LAUNCH: begin
                eng_start = 1'b1;
                s_d.st    = FS_EXEC;
            end
            FS_EXEC: begin
                if (eng_done) begin
                    cpl_valid = 1'b1;
                    s_d.st    = FS_IDLE;
                end
            end
            default: s_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign eng_chan   = s_q.chan;
    assign eng_param0 = s_q.p0;
    assign eng_param1 = s_q.p1;
    assign cpl_chan   = s_q.chan;
    assign cpl_next   = s_q.nxt[AW-1:0];
    assign cpl_chain  = s_q.chain;
    assign cpl_irq    = s_q.irq;
    assign err_chan   = s_q.chan;

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> (!eng_start && $stable(eng_chan)));

endmodule

// File: rtl/dcs_chan_bank.sv
module dcs_chan_bank import dcs_pkg::*; #(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SW  = 8,
    localparam int CH_W = $clog2(NCH),
    localparam int RA_W = CH_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [RA_W-1:0]          reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    output logic [DW-1:0]            reg_rdata,
    input  logic                     cpl_valid,
    input  logic [CH_W-1:0]          cpl_chan,
    input  logic [AW-1:0]            cpl_next,
    input  logic                     cpl_chain,
    input  logic                     cpl_irq,
    input  logic                     err_valid,
    input  logic [CH_W-1:0]          err_chan,
    output logic [NCH-1:0][AW-1:0]   ptr_o,
    output logic [NCH-1:0]           req_o,
    output logic [NCH-1:0]           irq_o,
    output logic [NCH-1:0]           err_o
);

    localparam logic [SW-1:0] SEMA_MAX = '1;

    typedef struct packed {
        logic [NCH-1:0][AW-1:0] ptr;
        logic [NCH-1:0][SW-1:0] sema;
        logic [NCH-1:0]         irq;
        logic [NCH-1:0]         err;
    } bank_t;

    bank_t b_d, b_q;

    logic [CH_W-1:0] sel_ch;
    logic [1:0]      sel_reg;
    logic [NCH-1:0]  ptr_wr, sema_wr, stat_wr, cpl_hit, err_hit;

    assign sel_ch  = reg_addr[RA_W-1:2];
    assign sel_reg = reg_addr[1:0];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ptr_wr[i]  = reg_we && (sel_ch == CH_W'(i)) && (sel_reg == SEL_PTR);
            sema_wr[i] = reg_we && (sel_ch == CH_W'(i)) && (sel_reg == SEL_SEMA);
            stat_wr[i] = reg_we && (sel_ch == CH_W'(i)) && (sel_reg == SEL_STAT);
            cpl_hit[i] = cpl_valid && (cpl_chan == CH_W'(i));
            err_hit[i] = err_valid && (err_chan == CH_W'(i));
        end
    end

    always_comb begin
        logic [SW:0] sum;
        logic        big;
        b_d = b_q;
        for (int i = 0; i < NCH; i++) begin
            if (ptr_wr[i])                 b_d.ptr[i] = reg_wdata[AW-1:0];
            if (cpl_hit[i] && cpl_chain)   b_d.ptr[i] = cpl_next;

            sum = {1'b0, b_q.sema[i]};
            big = 1'b0;
            if (sema_wr[i]) begin
                sum = sum + {1'b0, reg_wdata[SW-1:0]};
                big = |reg_wdata[DW-1:SW];
            end
            if (cpl_hit[i] && (sum != '0)) sum = sum - 1'b1;
            if (big || sum[SW]) b_d.sema[i] = SEMA_MAX;
            else                b_d.sema[i] = sum[SW-1:0];

            if (stat_wr[i] && reg_wdata[0]) b_d.irq[i] = 1'b0;
            if (cpl_hit[i] && cpl_irq)      b_d.irq[i] = 1'b1;

            if (stat_wr[i] && reg_wdata[1]) b_d.err[i] = 1'b0;
            if (err_hit[i]) begin
                b_d.err[i]  = 1'b1;
                b_d.sema[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) b_q <= '0;
        else     b_q <= b_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel_reg)
            SEL_PTR:  reg_rdata = DW'(b_q.ptr[sel_ch]);
            SEL_SEMA: reg_rdata = DW'(b_q.sema[sel_ch]);
            SEL_STAT: reg_rdata = DW'({b_q.err[sel_ch], b_q.irq[sel_ch]});
            default:  reg_rdata = '0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            req_o[i] = (b_q.sema[i] != '0) && !b_q.err[i];
        end
    end

    assign ptr_o = b_q.ptr;
    assign irq_o = b_q.irq;
    assign err_o = b_q.err;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_sema_dec_R6: assert property (@(posedge clk) disable iff (rst)
            (cpl_hit[g] && !sema_wr[g] && !err_hit[g] && (b_q.sema[g] != '0))
            |=> (b_q.sema[g] == $past(b_q.sema[g]) - 1'b1));

        assert_err_clears_sema_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(b_q.err[g]) |-> (b_q.sema[g] == '0));

        assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (b_q.irq[g] && !(stat_wr[g] && reg_wdata[0])) |=> b_q.irq[g]);
    end

endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq #(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SW  = 8,
    localparam int CH_W = $clog2(NCH),
    localparam int RA_W = CH_W + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [AW-1:0]   mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [DW-1:0]   mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            eng_start,
    output logic [CH_W-1:0] eng_chan,
    output logic [DW-1:0]   eng_param0,
    output logic [DW-1:0]   eng_param1,
    input  logic            eng_done,
    output logic [NCH-1:0]  irq_o,
    output logic [NCH-1:0]  err_o
);

    logic [NCH-1:0][AW-1:0] ptr_vec;
    logic [NCH-1:0]         req_vec;
    logic                   gnt_any;
    logic [CH_W-1:0]        gnt_idx;
    logic                   take;
    logic                   cpl_valid, cpl_chain, cpl_irq, err_valid;
    logic [CH_W-1:0]        cpl_chan, err_chan;
    logic [AW-1:0]          cpl_next;

    dcs_chan_bank #(.NCH(NCH), .AW(AW), .DW(DW), .SW(SW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpl_valid (cpl_valid),
        .cpl_chan  (cpl_chan),
        .cpl_next  (cpl_next),
        .cpl_chain (cpl_chain),
        .cpl_irq   (cpl_irq),
        .err_valid (err_valid),
        .err_chan  (err_chan),
        .ptr_o     (ptr_vec),
        .req_o     (req_vec),
        .irq_o     (irq_o),
        .err_o     (err_o)
    );

    dcs_rr_arb #(.NCH(NCH)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req_vec),
        .take    (take),
        .any     (gnt_any),
        .gnt_idx (gnt_idx)
    );

    dcs_fetch #(.NCH(NCH), .AW(AW), .DW(DW)) u_fetch (
        .clk           (clk),
        .rst           (rst),
        .gnt_any       (gnt_any),
        .gnt_idx       (gnt_idx),
        .gnt_ptr       (ptr_vec[gnt_idx]),
        .take          (take),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .eng_start     (eng_start),
        .eng_chan      (eng_chan),
        .eng_param0    (eng_param0),
        .eng_param1    (eng_param1),
        .eng_done      (eng_done),
        .cpl_valid     (cpl_valid),
        .cpl_chan      (cpl_chan),
        .cpl_next      (cpl_next),
        .cpl_chain     (cpl_chain),
        .cpl_irq       (cpl_irq),
        .err_valid     (err_valid),
        .err_chan      (err_chan)
    );

    assert_no_fetch_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !mem_req_valid);

endmodule

// File: tb/desc_chain_seq_tb.sv
module desc_chain_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        eng_start;
    logic [1:0]  eng_chan;
    logic [31:0] eng_param0, eng_param1;
    logic        eng_done;
    logic [3:0]  irq_o, err_o;

    logic        mem_hold = 1'b0;
    logic        stall = 1'b0;
    logic        spur = 1'b0;
    logic        eng_done_r = 1'b0;
    int          eng_cnt = 0;

    logic [31:0] mem [0:63];
    logic [31:0] fetch_log [0:255];
    logic [1:0]  log_chan [0:63];
    logic [31:0] log_p0 [0:63];
    logic [31:0] log_p1 [0:63];
    int          n_fetch = 0;
    int          n_start = 0;
    int          n_done = 0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    assign mem_req_ready = !mem_hold;
    assign eng_done      = eng_done_r | spur;

    desc_chain_seq u_dut (
        .clk           (clk),
        .rst           (rst),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .eng_start     (eng_start),
        .eng_chan      (eng_chan),
        .eng_param0    (eng_param0),
        .eng_param1    (eng_param1),
        .eng_done      (eng_done),
        .irq_o         (irq_o),
        .err_o         (err_o)
    );

    // memory model: one-cycle response, addresses of 256 and above fail
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_err   <= (mem_req_addr >= 32'd256);
            mem_rsp_data  <= mem[mem_req_addr[7:2]];
            fetch_log[n_fetch % 256] <= mem_req_addr;
            n_fetch <= n_fetch + 1;
        end
    end

    // engine model: done three cycles after start unless stalled
    always @(posedge clk) begin
        eng_done_r <= 1'b0;
        if (eng_start) begin
            eng_cnt <= 3;
            log_chan[n_start % 64] <= eng_chan;
            log_p0[n_start % 64]   <= eng_param0;
            log_p1[n_start % 64]   <= eng_param1;
            n_start <= n_start + 1;
        end else if (eng_cnt != 0 && !stall) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) begin
                eng_done_r <= 1'b1;
                n_done <= n_done + 1;
            end
        end
    end

    function automatic logic [3:0] ra(input int ch, input int sel);
        return {ch[1:0], sel[1:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input int target, input string req);
        int k = 0;
        while (n_done < target && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({req, " completion count"}, 32'(n_done >= target), 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_start(input int target, input string req);
        int k = 0;
        while (n_start < target && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk({req, " start count"}, 32'(n_start >= target), 32'd1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int ch = 0; ch < 4; ch++) begin
            for (int s = 0; s < 3; s++) begin
                rd(ra(ch, s), d);
                chk("R1 register after reset", d, 32'd0);
            end
        end
        chk("R1 irq_o after reset", 32'(irq_o), 32'd0);
        chk("R1 err_o after reset", 32'(err_o), 32'd0);
        chk("R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
        chk("R1 eng_start after reset", 32'(eng_start), 32'd0);
    endtask

    task automatic t_single;
        logic [31:0] d;
        int f0, s0, d0;
        wr(ra(1, 0), 32'hDEAD_BEE0);
        rd(ra(1, 0), d);
        chk("R2 pointer readback", d, 32'hDEAD_BEE0);
        wr(ra(1, 0), 32'h0000_0000);
        rd(ra(1, 0), d);
        chk("R2 pointer rewrite", d, 32'h0);
        f0 = n_fetch; s0 = n_start; d0 = n_done;
        wr(ra(1, 1), 32'd1);
        wait_done(d0 + 1, "R6 single");
        for (int w = 0; w < 4; w++) chk("R4 fetch address order", fetch_log[f0 + w], 32'(4 * w));
        chk("R4 exactly four fetches", 32'(n_fetch - f0), 32'd4);
        chk("R5 one start", 32'(n_start - s0), 32'd1);
        chk("R5 start channel", 32'(log_chan[s0]), 32'd1);
        chk("R5 param0", log_p0[s0], 32'hA000_0001);
        chk("R5 param1", log_p1[s0], 32'hA000_0002);
        rd(ra(1, 1), d);
        chk("R6 count decremented", d, 32'd0);
        rd(ra(1, 0), d);
        chk("R6 no chain keeps pointer", d, 32'h0);
        chk("R8 no irq without request bit", 32'(irq_o[1]), 32'd0);
    endtask

    task automatic t_chain;
        logic [31:0] d;
        int s0, d0;
        s0 = n_start; d0 = n_done;
        wr(ra(2, 0), 32'h10);
        wr(ra(2, 1), 32'd2);
        wait_done(d0 + 1, "R6 chain first");
        rd(ra(2, 0), d);
        chk("R6 chain reloads pointer", d, 32'h20);
        chk("R8 irq not raised by plain descriptor", 32'(irq_o[2]), 32'd0);
        wait_done(d0 + 2, "R6 chain second");
        rd(ra(2, 0), d);
        chk("R6 unchained second keeps pointer", d, 32'h20);
        rd(ra(2, 1), d);
        chk("R6 count after two", d, 32'd0);
        chk("R5 second descriptor param0", log_p0[s0 + 1], 32'hC000_0001);
        chk("R8 irq raised", 32'(irq_o[2]), 32'd1);
        rd(ra(2, 2), d);
        chk("R8 status irq bit", d, 32'd1);
        repeat (5) @(negedge clk);
        chk("R8 irq sticky", 32'(irq_o[2]), 32'd1);
        wr(ra(2, 2), 32'd1);
        chk("R8 irq cleared by write one", 32'(irq_o[2]), 32'd0);
    endtask

    task automatic t_spur;
        logic [31:0] d;
        int d0;
        mem_hold = 1'b1;
        d0 = n_done;
        wr(ra(1, 0), 32'h10);
        wr(ra(1, 1), 32'd1);
        @(negedge clk); spur = 1'b1;
        @(negedge clk); spur = 1'b0;
        repeat (3) @(negedge clk);
        rd(ra(1, 1), d);
        chk("R10 stray done leaves count", d, 32'd1);
        rd(ra(1, 0), d);
        chk("R10 stray done leaves pointer", d, 32'h10);
        mem_hold = 1'b0;
        wait_done(d0 + 1, "R10 real completion");
        rd(ra(1, 0), d);
        chk("R6 chained pointer after real done", d, 32'h20);
        rd(ra(1, 1), d);
        chk("R10 single decrement", d, 32'd0);
    endtask

    task automatic t_sat_err;
        logic [31:0] d;
        int s0, f1, d0;
        mem_hold = 1'b1;
        s0 = n_start;
        wr(ra(0, 0), 32'h100);
        wr(ra(0, 1), 32'd200);
        wr(ra(0, 1), 32'd100);
        rd(ra(0, 1), d);
        chk("R3 add saturates", d, 32'd255);
        mem_hold = 1'b0;
        repeat (10) @(negedge clk);
        chk("R9 error flag", 32'(err_o[0]), 32'd1);
        rd(ra(0, 1), d);
        chk("R9 count zeroed", d, 32'd0);
        rd(ra(0, 2), d);
        chk("R9 status error bit", d, 32'd2);
        chk("R9 no engine start", 32'(n_start - s0), 32'd0);
        wr(ra(0, 1), 32'd1);
        f1 = n_fetch;
        repeat (20) @(negedge clk);
        chk("R9 halted channel does not fetch", 32'(n_fetch - f1), 32'd0);
        rd(ra(0, 1), d);
        chk("R3 add from zero", d, 32'd1);
        d0 = n_done;
        wr(ra(0, 0), 32'h0);
        wr(ra(0, 2), 32'd2);
        wait_done(d0 + 1, "R9 resume");
        chk("R9 error cleared", 32'(err_o[0]), 32'd0);
        rd(ra(0, 1), d);
        chk("R9 resumed descriptor consumed count", d, 32'd0);
    endtask

    task automatic t_rr;
        int s0, d0, f1;
        s0 = n_start; d0 = n_done;
        stall = 1'b1;
        wr(ra(3, 0), 32'h30);
        wr(ra(3, 1), 32'd1);
        wait_start(s0 + 1, "R7 first grant");
        f1 = n_fetch;
        for (int ch = 0; ch < 3; ch++) begin
            wr(ra(ch, 0), 32'h30);
            wr(ra(ch, 1), 32'd2);
        end
        repeat (10) @(negedge clk);
        chk("R7 no fetch while engine busy", 32'(n_fetch - f1), 32'd0);
        chk("R7 grant held", 32'(n_start - s0), 32'd1);
        stall = 1'b0;
        wait_done(d0 + 7, "R7 rotation");
        chk("R7 first owner", 32'(log_chan[s0]), 32'd3);
        for (int k = 0; k < 6; k++) chk("R7 round-robin order", 32'(log_chan[s0 + 1 + k]), 32'(k % 3));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[0]  = 32'h40; mem[1]  = 32'd0; mem[2]  = 32'hA000_0001; mem[3]  = 32'hA000_0002;
        mem[4]  = 32'h20; mem[5]  = 32'd4; mem[6]  = 32'hB000_0001; mem[7]  = 32'hB000_0002;
        mem[8]  = 32'h30; mem[9]  = 32'd1; mem[10] = 32'hC000_0001; mem[11] = 32'hC000_0002;
        mem[12] = 32'h30; mem[13] = 32'd5; mem[14] = 32'hD000_0001; mem[15] = 32'hD000_0002;
        mem[16] = 32'h10; mem[17] = 32'd0; mem[18] = 32'hE000_0001; mem[19] = 32'hE000_0002;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_chain();
        t_spur();
        t_sat_err();
        t_rr();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule